// File: doc/BRIEF.md
# Integer Execute ALU with Barrel Shifter

This block performs the integer register-register and register-immediate operations of a simple 32-bit load/store processor. It receives two register operands, a 16-bit immediate, a 5-bit shift field, an operation code and a flag that selects the immediate in place of the second register operand. The result is registered, so each operation presented on a clock edge is visible on the outputs after that edge.

Supported work: wrapping and trapping add and subtract, AND/OR/XOR/NOR, signed and unsigned set-on-less-than, left/right logical and right arithmetic shifts by a fixed or register-held amount, and loading an immediate into the upper half-word. A trapping operation that overflows raises an exception flag together with a write-suppress output so that the destination register is left unchanged; the wrapped result is still driven.

Top module: `int_exec_alu`

## Requirements
- R1: While `rst_n` is low, `result`, `ovf_trap` and `wr_suppress` are all 0.
- R2: Inputs sampled on a rising clock edge determine the outputs from that edge until the next one; before the edge the outputs keep the previous operation's values.
- R3: Codes 0 (trapping add) and 2 (trapping subtract) set `ovf_trap` when the two's-complement result does not fit in 32 bits; codes 1 (wrapping add) and 3 (wrapping subtract) never set it. The first operand is `opnd_a`; subtract computes `opnd_a` minus the second operand.
- R4: `wr_suppress` is 1 exactly when `ovf_trap` is 1, and `result` still carries the 32-bit wrapped sum or difference.
- R5: With `use_imm` = 1 the second operand is the immediate: zero-extended for codes 4 (AND), 5 (OR), 6 (XOR) and 9 (unsigned less-than), sign-extended for codes 0, 1, 2, 3, 7 and 8.
- R6: Codes 4, 5, 6 and 7 give bitwise AND, OR, XOR and NOR (inverse of OR) of the two operands.
- R7: Code 8 gives 1 when `opnd_a` is less than the second operand as signed numbers, code 9 as unsigned numbers, and 0 otherwise; bits 31:1 are 0.
- R8: Codes 10, 11, 12 shift `opnd_b` left logical, right logical and right arithmetic by `shamt`; codes 13, 14, 15 do the same by bits 4:0 of `opnd_a`, ignoring its upper bits. `use_imm` has no effect on shifts.
- R9: Code 16 gives the immediate in bits 31:16 and zeros in bits 15:0, independent of the operands.
- R10: Codes 17 to 31 give result 0 and no overflow.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_sel | input | 5 | Operation code (see requirements) |
| use_imm | input | 1 | Use the extended immediate as second operand |
| opnd_a | input | 32 | First register operand (also variable shift amount) |
| opnd_b | input | 32 | Second register operand (also shifted value) |
| imm16 | input | 16 | Immediate field |
| shamt | input | 5 | Fixed shift amount |
| result | output | 32 | Registered result |
| ovf_trap | output | 1 | Registered signed-overflow exception |
| wr_suppress | output | 1 | Registered destination write inhibit |

## Verification
Every result and both flags are due one rising edge after the inputs that produce them, since a single register stage sits between the combinational datapath and the ports. The bench changes inputs on the falling edge and compares on the following falling edge, so exactly one capturing edge lies between stimulus and check. The latency scenario additionally looks just after driving new inputs, before the edge, to confirm the old values are still held.

// File: rtl/int_alu_pkg.sv
package int_alu_pkg;

  localparam int WORD_W  = 32;
  localparam int IMM_W   = 16;
  localparam int SHAMT_W = $clog2(WORD_W);
  localparam int OP_W    = 5;

  typedef enum logic [OP_W-1:0] {
    OP_ADD  = 5'd0,
    OP_ADDU = 5'd1,
    OP_SUB  = 5'd2,
    OP_SUBU = 5'd3,
    OP_AND  = 5'd4,
    OP_OR   = 5'd5,
    OP_XOR  = 5'd6,
    OP_NOR  = 5'd7,
    OP_SLT  = 5'd8,
    OP_SLTU = 5'd9,
    OP_SLL  = 5'd10,
    OP_SRL  = 5'd11,
    OP_SRA  = 5'd12,
    OP_SLLV = 5'd13,
    OP_SRLV = 5'd14,
    OP_SRAV = 5'd15,
    OP_LUI  = 5'd16
  } alu_op_e;

  // Widen the immediate to a full word, replicating the sign or zeros.
  function automatic logic [WORD_W-1:0] widen_imm(input logic [IMM_W-1:0] imm,
                                                  input logic             sgn);
    return {{(WORD_W-IMM_W){sgn & imm[IMM_W-1]}}, imm};
  endfunction

  // Same-sign operands and a sum whose sign differs.
  function automatic logic add_overflows(input logic [WORD_W-1:0] a,
                                         input logic [WORD_W-1:0] b,
                                         input logic [WORD_W-1:0] s);
    return (a[WORD_W-1] == b[WORD_W-1]) && (s[WORD_W-1] != a[WORD_W-1]);
  endfunction

  // Opposite-sign operands and a difference whose sign departs from a.
  function automatic logic sub_overflows(input logic [WORD_W-1:0] a,
                                         input logic [WORD_W-1:0] b,
                                         input logic [WORD_W-1:0] d);
    return (a[WORD_W-1] != b[WORD_W-1]) && (d[WORD_W-1] != a[WORD_W-1]);
  endfunction

endpackage

// File: rtl/int_alu_operand.sv
module int_alu_operand
  import int_alu_pkg::*;
(
  input  alu_op_e           op,
  input  logic              use_imm,
  input  logic [WORD_W-1:0] reg_b,
  input  logic [IMM_W-1:0]  imm,
  output logic [WORD_W-1:0] src_b
);
  logic zero_ext;

  always_comb begin
    case (op)
      OP_AND, OP_OR, OP_XOR, OP_SLTU: zero_ext = 1'b1;
      default:                        zero_ext = 1'b0;
    endcase
  end

  assign src_b = use_imm ? widen_imm(imm, ~zero_ext) : reg_b;
endmodule

// File: rtl/int_alu_addsub.sv
module int_alu_addsub
  import int_alu_pkg::*;
(
  input  alu_op_e           op,
  input  logic [WORD_W-1:0] a,
  input  logic [WORD_W-1:0] b,
  output logic [WORD_W-1:0] sum,
  output logic              ovf_evt,
  output logic              lt_signed,
  output logic              lt_unsigned
);
  logic do_sub;
  logic traps;

  assign do_sub = (op == OP_SUB) || (op == OP_SUBU);
  assign traps  = (op == OP_ADD) || (op == OP_SUB);
  assign sum    = do_sub ? (a - b) : (a + b);

  assign ovf_evt = traps && (do_sub ? sub_overflows(a, b, sum)
                                    : add_overflows(a, b, sum));

  assign lt_signed   = $signed(a) < $signed(b);
  assign lt_unsigned = a < b;
endmodule

// File: rtl/int_alu_shifter.sv
module int_alu_shifter
  import int_alu_pkg::*;
(
  input  alu_op_e            op,
  input  logic [WORD_W-1:0]  value,
  input  logic [SHAMT_W-1:0] fixed_amt,
  input  logic [WORD_W-1:0]  reg_amt,
  output logic [WORD_W-1:0]  shifted
);
  logic [SHAMT_W-1:0] amt;
  logic               from_reg;

  assign from_reg = (op == OP_SLLV) || (op == OP_SRLV) || (op == OP_SRAV);
  assign amt      = from_reg ? reg_amt[SHAMT_W-1:0] : fixed_amt;

  always_comb begin
    case (op)
      OP_SLL, OP_SLLV: shifted = value << amt;
      OP_SRL, OP_SRLV: shifted = value >> amt;
      OP_SRA, OP_SRAV: shifted = WORD_W'($signed(value) >>> amt);
      default:         shifted = '0;
    endcase
  end
endmodule

// File: rtl/int_exec_alu.sv
module int_exec_alu
  import int_alu_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [OP_W-1:0]      op_sel,
  input  logic                 use_imm,
  input  logic [WORD_W-1:0]    opnd_a,
  input  logic [WORD_W-1:0]    opnd_b,
  input  logic [IMM_W-1:0]     imm16,
  input  logic [SHAMT_W-1:0]   shamt,
  output logic [WORD_W-1:0]    result,
  output logic                 ovf_trap,
  output logic                 wr_suppress
);
  alu_op_e           op;
  logic [WORD_W-1:0] src_b;
  logic [WORD_W-1:0] sum;
  logic [WORD_W-1:0] shifted;
  logic [WORD_W-1:0] nxt_result;
  logic              ovf_evt;
  logic              lt_signed;
  logic              lt_unsigned;

  assign op = alu_op_e'(op_sel);

  int_alu_operand u_operand (
    .op(op), .use_imm(use_imm), .reg_b(opnd_b), .imm(imm16), .src_b(src_b)
  );

  int_alu_addsub u_addsub (
    .op(op), .a(opnd_a), .b(src_b), .sum(sum), .ovf_evt(ovf_evt),
    .lt_signed(lt_signed), .lt_unsigned(lt_unsigned)
  );

  int_alu_shifter u_shifter (
    .op(op), .value(opnd_b), .fixed_amt(shamt), .reg_amt(opnd_a), .shifted(shifted)
  );

  always_comb begin
    case (op)
      OP_ADD, OP_ADDU, OP_SUB, OP_SUBU: nxt_result = sum;
      OP_AND:  nxt_result = opnd_a & src_b;
      OP_OR:   nxt_result = opnd_a | src_b;
      OP_XOR:  nxt_result = opnd_a ^ src_b;
      OP_NOR:  nxt_result = ~(opnd_a | src_b);
      OP_SLT:  nxt_result = {{(WORD_W-1){1'b0}}, lt_signed};
      OP_SLTU: nxt_result = {{(WORD_W-1){1'b0}}, lt_unsigned};
      OP_SLL, OP_SRL, OP_SRA, OP_SLLV, OP_SRLV, OP_SRAV: nxt_result = shifted;
      OP_LUI:  nxt_result = {imm16, {(WORD_W-IMM_W){1'b0}}};
      default: nxt_result = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      result      <= '0;
      ovf_trap    <= 1'b0;
      wr_suppress <= 1'b0;
    end else begin
      result      <= nxt_result;
      ovf_trap    <= ovf_evt;
      wr_suppress <= ovf_evt;
    end
  end

  // R1: outputs are cleared while reset is held
  always_comb begin
    if (!rst_n) begin
      assert_reset_clear_R1: assert (result == '0 && !ovf_trap && !wr_suppress)
        else $error("R1 outputs not cleared in reset");
    end
  end

  // R3: the wrapping forms never raise the exception
  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(op_sel) == OP_ADDU || $past(op_sel) == OP_SUBU) |-> !ovf_trap);

  // R4: an adder overflow event shows up as a suppressed write one edge later
  assert_suppress_follows_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $past(ovf_evt) |-> (wr_suppress && ovf_trap));

  // R7: comparisons only ever yield 0 or 1
  assert_slt_bit_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(op_sel) == OP_SLT || $past(op_sel) == OP_SLTU) |-> (result[WORD_W-1:1] == '0));

  // R9: upper-immediate load clears the low half
  assert_lui_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(op_sel) == OP_LUI) |-> (result[WORD_W-IMM_W-1:0] == '0));

  // R10: unassigned codes give zero and no trap
  assert_unused_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(op_sel) > OP_LUI) |-> (result == '0 && !ovf_trap));
endmodule

// File: tb/int_exec_alu_bench.sv
module int_exec_alu_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  op_sel = '0;
  logic        use_imm = 1'b0;
  logic [31:0] opnd_a = '0;
  logic [31:0] opnd_b = '0;
  logic [15:0] imm16 = '0;
  logic [4:0]  shamt = '0;
  logic [31:0] result;
  logic        ovf_trap;
  logic        wr_suppress;

  int n_checks = 0;
  int n_fails  = 0;
  bit done     = 1'b0;

  always #10 clk = ~clk;

  int_exec_alu u_int_exec_alu (
    .clk(clk), .rst_n(rst_n), .op_sel(op_sel), .use_imm(use_imm),
    .opnd_a(opnd_a), .opnd_b(opnd_b), .imm16(imm16), .shamt(shamt),
    .result(result), .ovf_trap(ovf_trap), .wr_suppress(wr_suppress)
  );

  // Independent reference built from the requirement text.
  function automatic void model(input logic [4:0] op, input logic [31:0] a,
                                input logic [31:0] b, input logic [15:0] im,
                                input logic [4:0] sh, input logic ui,
                                output logic [31:0] r, output logic v);
    logic [31:0] bb;
    logic signed [32:0] wide;
    bit zx;
    zx = (op == 4) || (op == 5) || (op == 6) || (op == 9);
    bb = !ui ? b : (zx ? {16'h0000, im} : {{16{im[15]}}, im});
    v = 1'b0;
    r = '0;
    case (op)
      0, 1: begin
        wide = $signed({a[31], a}) + $signed({bb[31], bb});
        r = wide[31:0];
        v = (op == 0) && (wide[32] != wide[31]);
      end
      2, 3: begin
        wide = $signed({a[31], a}) - $signed({bb[31], bb});
        r = wide[31:0];
        v = (op == 2) && (wide[32] != wide[31]);
      end
      4: r = a & bb;
      5: r = a | bb;
      6: r = a ^ bb;
      7: r = ~a & ~bb;
      8: r = ($signed(a) < $signed(bb)) ? 32'd1 : 32'd0;
      9: r = (a < bb) ? 32'd1 : 32'd0;
      10: r = b << sh;
      11: r = b >> sh;
      12: r = 32'($signed(b) >>> sh);
      13: r = b << a[4:0];
      14: r = b >> a[4:0];
      15: r = 32'($signed(b) >>> a[4:0]);
      16: r = {im, 16'h0000};
      default: r = '0;
    endcase
  endfunction

  task automatic check(input string req, input string what,
                       input logic [31:0] got, input logic [31:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, got, exp);
    end
  endtask

  // Drive on a falling edge, compare on the next falling edge.
  task automatic run_op(input string req, input logic [4:0] op, input logic [31:0] a,
                        input logic [31:0] b, input logic [15:0] im,
                        input logic [4:0] sh, input logic ui);
    logic [31:0] er;
    logic ev;
    @(negedge clk);
    op_sel = op; opnd_a = a; opnd_b = b; imm16 = im; shamt = sh; use_imm = ui;
    model(op, a, b, im, sh, ui, er, ev);
    @(negedge clk);
    check(req, "result", result, er);
    check(req, "ovf_trap", {31'd0, ovf_trap}, {31'd0, ev});
    check(req, "wr_suppress", {31'd0, wr_suppress}, {31'd0, ev});
  endtask

  task automatic t_reset_R1();
    #5;
    check("R1", "result", result, 32'h0);
    check("R1", "ovf_trap", {31'd0, ovf_trap}, 32'h0);
    check("R1", "wr_suppress", {31'd0, wr_suppress}, 32'h0);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic t_latency_R2();
    run_op("R2", 5'd5, 32'h0000_00F0, 32'h0000_000F, 16'h0, 5'd0, 1'b0);
    @(negedge clk);
    op_sel = 5'd16; imm16 = 16'hBEEF;
    #2 check("R2", "held before edge", result, 32'h0000_00FF);
    @(negedge clk);
    check("R2", "after edge", result, 32'hBEEF_0000);
  endtask

  task automatic t_overflow_R3_R4();
    run_op("R3", 5'd0, 32'h7FFF_FFFF, 32'h1, 16'h0, 5'd0, 1'b0);
    run_op("R3", 5'd0, 32'h8000_0000, 32'hFFFF_FFFF, 16'h0, 5'd0, 1'b0);
    run_op("R3", 5'd0, 32'h7FFF_FFFF, 32'h0, 16'h0001, 5'd0, 1'b1);
    run_op("R3", 5'd0, 32'h7FFF_FFFE, 32'h1, 16'h0, 5'd0, 1'b0);
    run_op("R3", 5'd2, 32'h8000_0000, 32'h1, 16'h0, 5'd0, 1'b0);
    run_op("R3", 5'd2, 32'h7FFF_FFFF, 32'hFFFF_FFFF, 16'h0, 5'd0, 1'b0);
    run_op("R3", 5'd2, 32'hFFFF_FFFF, 32'h7FFF_FFFF, 16'h0, 5'd0, 1'b0);
    run_op("R3", 5'd1, 32'h7FFF_FFFF, 32'h1, 16'h0, 5'd0, 1'b0);
    run_op("R3", 5'd3, 32'h8000_0000, 32'h1, 16'h0, 5'd0, 1'b0);
    run_op("R4", 5'd0, 32'h8000_0000, 32'h8000_0000, 16'h0, 5'd0, 1'b0);
    check("R4", "wrapped sum kept", result, 32'h0);
  endtask

  task automatic t_immediate_R5();
    run_op("R5", 5'd1, 32'h0000_0010, 32'h0, 16'hFFFF, 5'd0, 1'b1);
    check("R5", "addiu sign-extend", result, 32'h0000_000F);
    run_op("R5", 5'd5, 32'h0, 32'h0, 16'h8001, 5'd0, 1'b1);
    check("R5", "ori zero-extend", result, 32'h0000_8001);
    run_op("R5", 5'd4, 32'hFFFF_FFFF, 32'h0, 16'hF0F0, 5'd0, 1'b1);
    run_op("R5", 5'd6, 32'h1234_5678, 32'h0, 16'hFFFF, 5'd0, 1'b1);
    run_op("R5", 5'd8, 32'h0, 32'h0, 16'h8000, 5'd0, 1'b1);
    run_op("R5", 5'd9, 32'h0000_1000, 32'h0, 16'h8000, 5'd0, 1'b1);
    check("R5", "sltiu zero-extend", result, 32'h1);
  endtask

  task automatic t_logic_R6();
    run_op("R6", 5'd4, 32'hF0F0_1234, 32'hFF00_FF00, 16'h0, 5'd0, 1'b0);
    run_op("R6", 5'd5, 32'h0F0F_0000, 32'h00F0_00F0, 16'h0, 5'd0, 1'b0);
    run_op("R6", 5'd6, 32'hAAAA_5555, 32'hFFFF_0000, 16'h0, 5'd0, 1'b0);
    run_op("R6", 5'd7, 32'h0000_00FF, 32'hFF00_0000, 16'h0, 5'd0, 1'b0);
    check("R6", "nor value", result, 32'h00FF_FF00);
  endtask

  task automatic t_compare_R7();
    run_op("R7", 5'd8, 32'hFFFF_FFFF, 32'h1, 16'h0, 5'd0, 1'b0);
    check("R7", "signed -1<1", result, 32'h1);
    run_op("R7", 5'd9, 32'hFFFF_FFFF, 32'h1, 16'h0, 5'd0, 1'b0);
    check("R7", "unsigned max<1", result, 32'h0);
    run_op("R7", 5'd8, 32'h5, 32'h5, 16'h0, 5'd0, 1'b0);
    run_op("R7", 5'd9, 32'h3, 32'h8000_0000, 16'h0, 5'd0, 1'b0);
  endtask

  task automatic t_shift_R8();
    run_op("R8", 5'd10, 32'h0, 32'h8000_0001, 16'h0, 5'd4, 1'b0);
    run_op("R8", 5'd11, 32'h0, 32'h8000_0000, 16'h0, 5'd31, 1'b0);
    run_op("R8", 5'd12, 32'h0, 32'h8000_0000, 16'h0, 5'd31, 1'b0);
    check("R8", "sra fills sign", result, 32'hFFFF_FFFF);
    run_op("R8", 5'd13, 32'hFFFF_FFE3, 32'h0000_0001, 16'h0, 5'd0, 1'b0);
    check("R8", "sllv low 5 bits", result, 32'h0000_0008);
    run_op("R8", 5'd14, 32'h0000_0124, 32'hF000_0000, 16'h0, 5'd7, 1'b0);
    run_op("R8", 5'd15, 32'h0000_0048, 32'h8000_0000, 16'h0, 5'd0, 1'b0);
    run_op("R8", 5'd10, 32'h0, 32'h0000_0003, 16'hFFFF, 5'd1, 1'b1);
    check("R8", "use_imm ignored", result, 32'h0000_0006);
  endtask

  task automatic t_lui_R9();
    run_op("R9", 5'd16, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 16'h1234, 5'd3, 1'b0);
    check("R9", "lui value", result, 32'h1234_0000);
  endtask

  task automatic t_unused_R10();
    run_op("R10", 5'd17, 32'h7FFF_FFFF, 32'h7FFF_FFFF, 16'hFFFF, 5'd1, 1'b0);
    run_op("R10", 5'd31, 32'h8000_0000, 32'h8000_0000, 16'hFFFF, 5'd1, 1'b1);
  endtask

  initial begin
    t_reset_R1();
    t_latency_R2();
    t_overflow_R3_R4();
    t_immediate_R5();
    t_logic_R6();
    t_compare_R7();
    t_shift_R8();
    t_lui_R9();
    t_unused_R10();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  end
endmodule